// File: doc/BRIEF.md
# Receive Resource Ring Reader

This block walks a circular table of receive buffer descriptors held in system memory. Each descriptor is four 16-bit words: a buffer base address split into a low and a high half, then a buffer size in words, also split low and high. When software asks for the next resource, the block reads the four words at the current read pointer and latches them as the active buffer base and word count. It then moves the read pointer on by one descriptor. If the pointer lands on the end address of the ring, it returns to the start address. If the pointer then meets the write pointer, which marks where software will add the next descriptor, the block raises a sticky exhausted flag.

The four ring pointers are written through a small register port. Each pointer is a 16-bit byte offset inside a 64 KiB window whose upper half comes from `upper_base`. A width mode selects 16-bit slots (8-byte descriptors) or 32-bit slots, where each word sits in a doubled slot (16-byte descriptors). Clearing the exhausted flag by writing 1 to it also starts a new fetch at once, so software can refill the ring and resume with a single write.

Top module: `rx_ring_reader`

## Requirements
- R1: After reset, all four pointers, `res_base` and `res_count` are zero, `busy` and `exhausted` are 0 and `mem_req` is 0.
- R2: When `ptr_wr_en` is 1 and the block is idle, `ptr_wr_data` with bit 0 forced to 0 is stored in the pointer chosen by `ptr_wr_sel`: 0 start, 1 end, 2 read, 3 write.
- R3: A fetch makes four memory reads in order. Word i is read at address {`upper_base`, read pointer + i*2} when `wide_mode` is 0, and at {`upper_base`, read pointer + i*4} when `wide_mode` is 1, with the low half wrapping modulo 2^16. `mem_req` and `mem_addr` hold steady until `mem_ack` is 1.
- R4: Word 0 goes to `res_base[15:0]`, word 1 to `res_base[31:16]`, word 2 to `res_count[15:0]` and word 3 to `res_count[31:16]`.
- R5: After the fourth word, the read pointer advances by 8 bytes (`wide_mode`=0) or 16 bytes (`wide_mode`=1), modulo 2^16.
- R6: If the advanced read pointer equals the end pointer, it is replaced by the start pointer.
- R7: If the read pointer, after any wrap, equals the write pointer, `exhausted` becomes 1. It stays 1 through later fetches until it is cleared.
- R8: A `fetch_cmd` seen while idle makes `busy` 1 from the next cycle. `busy` returns to 0 one cycle after the fourth word is accepted, and this marks the command as complete. No memory request is made while idle.
- R9: A `stat_clr` pulse while `exhausted` is 1 clears `exhausted` and starts a fetch, just as `fetch_cmd` does. While `exhausted` is 0, `stat_clr` has no effect.
- R10: While `busy` is 1, `fetch_cmd`, the fetch trigger of `stat_clr` and pointer writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects 32-bit slots (16-byte descriptors) |
| upper_base | input | 16 | Upper half of every memory address |
| ptr_wr_en | input | 1 | Pointer register write strobe |
| ptr_wr_sel | input | 2 | Pointer select: 0 start, 1 end, 2 read, 3 write |
| ptr_wr_data | input | 16 | Pointer write value (bit 0 ignored) |
| fetch_cmd | input | 1 | Fetch-next-resource command pulse |
| stat_clr | input | 1 | Write-1-to-clear of the exhausted flag |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Memory read accepted, data valid |
| mem_rdata | input | 16 | Memory read data |
| res_base | output | 32 | Latched buffer base address |
| res_count | output | 32 | Latched buffer word count |
| rd_ptr | output | 16 | Current read pointer |
| exhausted | output | 1 | Sticky resource-exhausted flag |
| busy | output | 1 | Fetch in progress (command bit still set) |

## Verification
The assertions watch the request handshake on every cycle. They check that an unanswered request keeps its address, that no request is made while idle, and that the read pointer does not move during a fetch except in its advance cycle. They also check that after an advance the pointer never sits on the end address, and that the exhausted flag rises only from an advance and falls only after a clear. The actual descriptor values, the word order, the wrap and exhaustion arithmetic across both slot widths, the masking of bit 0 and the refetch started by a clear can only be shown by the bench's scenarios, which compare the latched results against values derived from a memory pattern.

// File: rtl/rrr_pkg.sv
package rrr_pkg;
  localparam int NUM_PTRS    = 4;
  localparam int ENTRY_WORDS = 4;

  typedef enum logic [1:0] {
    PTR_START = 2'd0,
    PTR_END   = 2'd1,
    PTR_RD    = 2'd2,
    PTR_WR    = 2'd3
  } ptr_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ADV   = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/rrr_ptr_bank.sv
module rrr_ptr_bank import rrr_pkg::*; #(
  parameter int WORD_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [1:0]                           wr_sel,
  input  logic [WORD_W-1:0]                    wr_data,
  input  logic                                 lock,
  input  logic                                 adv_en,
  input  logic [WORD_W-1:0]                    adv_ptr,
  output logic [NUM_PTRS-1:0][WORD_W-1:0]      ptrs
);
  logic [WORD_W-1:0] wr_even;
  assign wr_even = {wr_data[WORD_W-1:1], 1'b0};

  for (genvar i = 0; i < NUM_PTRS; i++) begin : g_ptr
    if (i == int'(PTR_RD)) begin : g_rd
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 ptrs[i] <= '0;
        else if (adv_en)                            ptrs[i] <= adv_ptr;
        else if (wr_en && !lock && wr_sel == 2'(i)) ptrs[i] <= wr_even;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 ptrs[i] <= '0;
        else if (wr_en && !lock && wr_sel == 2'(i)) ptrs[i] <= wr_even;
      end
    end
  end
endmodule

// File: rtl/rrr_fetch_seq.sv
module rrr_fetch_seq import rrr_pkg::*; #(
  parameter int WORD_W = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   go,
  input  logic                                   wide,
  input  logic [WORD_W-1:0]                      upper,
  input  logic [WORD_W-1:0]                      rd_ptr,
  input  logic                                   mem_ack,
  input  logic [WORD_W-1:0]                      mem_rdata,
  output logic                                   mem_req,
  output logic [2*WORD_W-1:0]                    mem_addr,
  output logic                                   busy,
  output logic                                   adv_evt,
  output logic [ENTRY_WORDS-1:0][WORD_W-1:0]     words
);
  localparam int IDX_W = $clog2(ENTRY_WORDS);

  fetch_st_e        state;
  logic [IDX_W-1:0] idx;
  logic             last_word;

  function automatic logic [WORD_W-1:0] slot_offset(input logic [IDX_W-1:0] i,
                                                    input logic w);
    logic [WORD_W-1:0] o;
    o = WORD_W'(i);
    return w ? (o << 2) : (o << 1);
  endfunction

  assign mem_req   = (state == ST_FETCH);
  assign mem_addr  = {upper, rd_ptr + slot_offset(idx, wide)};
  assign busy      = (state != ST_IDLE);
  assign adv_evt   = (state == ST_ADV);
  assign last_word = (idx == IDX_W'(ENTRY_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          state <= ST_FETCH;
          idx   <= '0;
        end
        ST_FETCH: if (mem_ack) begin
          if (last_word) state <= ST_ADV;
          else           idx   <= idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar w = 0; w < ENTRY_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          words[w] <= '0;
      else if (mem_req && mem_ack && idx == IDX_W'(w))     words[w] <= mem_rdata;
    end
  end
endmodule

// File: rtl/rrr_exh_flag.sv
module rrr_exh_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end
endmodule

// File: rtl/rx_ring_reader.sv
module rx_ring_reader import rrr_pkg::*; #(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_mode,
  input  logic [WORD_W-1:0]   upper_base,
  input  logic                ptr_wr_en,
  input  logic [1:0]          ptr_wr_sel,
  input  logic [WORD_W-1:0]   ptr_wr_data,
  input  logic                fetch_cmd,
  input  logic                stat_clr,
  output logic                mem_req,
  output logic [2*WORD_W-1:0] mem_addr,
  input  logic                mem_ack,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic [2*WORD_W-1:0] res_base,
  output logic [2*WORD_W-1:0] res_count,
  output logic [WORD_W-1:0]   rd_ptr,
  output logic                exhausted,
  output logic                busy
);
  logic [NUM_PTRS-1:0][WORD_W-1:0]    ptrs;
  logic [ENTRY_WORDS-1:0][WORD_W-1:0] words;
  logic [WORD_W-1:0] start_ptr, end_ptr, wr_ptr, next_rd;
  logic go, adv_evt, exh_hit, retrigger;

  function automatic logic [WORD_W-1:0] advance_ptr(input logic [WORD_W-1:0] cur,
                                                    input logic w,
                                                    input logic [WORD_W-1:0] s,
                                                    input logic [WORD_W-1:0] e);
    logic [WORD_W-1:0] n;
    n = cur + (w ? WORD_W'(16) : WORD_W'(8));
    return (n == e) ? s : n;
  endfunction

  assign start_ptr = ptrs[PTR_START];
  assign end_ptr   = ptrs[PTR_END];
  assign wr_ptr    = ptrs[PTR_WR];
  assign rd_ptr    = ptrs[PTR_RD];

  assign next_rd   = advance_ptr(rd_ptr, wide_mode, start_ptr, end_ptr);
  assign exh_hit   = adv_evt && (next_rd == wr_ptr);
  assign retrigger = stat_clr && exhausted;
  assign go        = !busy && (fetch_cmd || retrigger);

  assign res_base  = {words[1], words[0]};
  assign res_count = {words[3], words[2]};

  rrr_ptr_bank #(.WORD_W(WORD_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ptr_wr_en), .wr_sel(ptr_wr_sel), .wr_data(ptr_wr_data),
    .lock(busy), .adv_en(adv_evt), .adv_ptr(next_rd), .ptrs(ptrs)
  );

  rrr_fetch_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .wide(wide_mode),
    .upper(upper_base), .rd_ptr(rd_ptr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .busy(busy), .adv_evt(adv_evt), .words(words)
  );

  rrr_exh_flag u_exh (
    .clk(clk), .rst_n(rst_n), .set_evt(exh_hit),
    .clr_req(retrigger), .flag(exhausted)
  );
endmodule

// File: rtl/rx_ring_reader_chk.sv
module rx_ring_reader_chk #(
  parameter int WORD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fetch_cmd,
  input logic                stat_clr,
  input logic                mem_req,
  input logic                mem_ack,
  input logic [2*WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0]   rd_ptr,
  input logic [WORD_W-1:0]   start_ptr,
  input logic [WORD_W-1:0]   end_ptr,
  input logic                adv_evt,
  input logic                exhausted,
  input logic                busy
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R3

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R8

  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fetch_cmd) || $past(stat_clr)); // R8

  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !adv_evt |=> $stable(rd_ptr)); // R10

  AST_WRAP_OFF_END: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt && (start_ptr != end_ptr) |=> rd_ptr != end_ptr); // R6

  AST_EXH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exhausted) |-> $past(adv_evt)); // R7

  AST_EXH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exhausted) |-> $past(stat_clr)); // R9
endmodule

bind rx_ring_reader rx_ring_reader_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_cmd(fetch_cmd), .stat_clr(stat_clr),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .rd_ptr(rd_ptr), .start_ptr(start_ptr), .end_ptr(end_ptr),
  .adv_evt(adv_evt), .exhausted(exhausted), .busy(busy)
);

// File: tb/rx_ring_reader_test.sv
module rx_ring_reader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic [15:0] upper_base = 16'h00C3;
  logic        ptr_wr_en = 1'b0;
  logic [1:0]  ptr_wr_sel = 2'd0;
  logic [15:0] ptr_wr_data = 16'h0;
  logic        fetch_cmd = 1'b0;
  logic        stat_clr = 1'b0;
  logic        mem_req, mem_ack, exhausted, busy;
  logic [31:0] mem_addr, res_base, res_count;
  logic [15:0] mem_rdata, rd_ptr;
  logic [1:0]  ws_cnt = 2'd0;
  logic [1:0]  wait_cfg = 2'd0;
  int          ack_cnt = 0;
  int          total = 0;
  int          bad = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] pat(input logic [31:0] a);
    return a[15:0] ^ {a[23:16], a[31:24]} ^ 16'h5A3C;
  endfunction

  assign mem_rdata = pat(mem_addr);
  assign mem_ack   = mem_req && (ws_cnt == wait_cfg);

  always @(posedge clk) begin
    if (!mem_req || mem_ack) ws_cnt <= 2'd0;
    else                     ws_cnt <= ws_cnt + 2'd1;
    if (mem_req && mem_ack)  ack_cnt <= ack_cnt + 1;
  end

  rx_ring_reader uut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .upper_base(upper_base),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel), .ptr_wr_data(ptr_wr_data),
    .fetch_cmd(fetch_cmd), .stat_clr(stat_clr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .res_base(res_base), .res_count(res_count), .rd_ptr(rd_ptr),
    .exhausted(exhausted), .busy(busy)
  );

  // {wide, start, end, rd, wr, expected rd, expected exhausted}
  localparam logic [81:0] VEC [7] = '{
    {1'b0, 16'h0100, 16'h0200, 16'h0100, 16'h0180, 16'h0108, 1'b0},
    {1'b0, 16'h0100, 16'h0200, 16'h01F8, 16'h0150, 16'h0100, 1'b0},
    {1'b1, 16'h0100, 16'h0200, 16'h01F0, 16'h0100, 16'h0100, 1'b1},
    {1'b1, 16'h0400, 16'h0480, 16'h0420, 16'h0430, 16'h0430, 1'b1},
    {1'b0, 16'h0101, 16'h0111, 16'h0109, 16'h0001, 16'h0100, 1'b0},
    {1'b0, 16'h0000, 16'h0000, 16'hFFF8, 16'h0000, 16'h0000, 1'b1},
    {1'b1, 16'h2000, 16'h3000, 16'h2000, 16'h9000, 16'h2010, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ptr_wr_en = 1'b0; fetch_cmd = 1'b0; stat_clr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_ptr(input logic [1:0] sel, input logic [15:0] val);
    ptr_wr_en = 1'b1; ptr_wr_sel = sel; ptr_wr_data = val;
    @(negedge clk);
    ptr_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60 && busy; i++) @(negedge clk);
  endtask

  task automatic pulse_cmd();
    fetch_cmd = 1'b1;
    @(negedge clk);
    fetch_cmd = 1'b0;
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 exhausted", exhausted, 0);
    check("R1 rd_ptr", rd_ptr, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 res_base", res_base, 0);
    check("R1 res_count", res_count, 0);

    // R9 clear while not exhausted does nothing
    pulse_clr();
    check("R9 no refetch busy", busy, 0);
    check("R9 no refetch rd", rd_ptr, 0);

    // Table walk: R2 R3 R4 R5 R6 R7
    foreach (VEC[k]) begin
      logic [15:0] rdm, step, lo;
      logic [31:0] eb, ec;
      int a0;
      do_reset();
      wide_mode = VEC[k][81];
      write_ptr(2'd0, VEC[k][80:65]);
      write_ptr(2'd1, VEC[k][64:49]);
      write_ptr(2'd2, VEC[k][48:33]);
      write_ptr(2'd3, VEC[k][32:17]);
      rdm  = {VEC[k][48:34], 1'b0};
      check("R2 rd masked", rd_ptr, rdm);
      step = VEC[k][81] ? 16'd4 : 16'd2;
      a0 = ack_cnt;
      pulse_cmd();
      check("R8 busy after cmd", busy, 1);
      wait_idle();
      lo = rdm;               eb[15:0]  = pat({upper_base, lo});
      lo = rdm + step;        eb[31:16] = pat({upper_base, lo});
      lo = rdm + 16'(2*step); ec[15:0]  = pat({upper_base, lo});
      lo = rdm + 16'(3*step); ec[31:16] = pat({upper_base, lo});
      check("R4 res_base", res_base, eb);
      check("R3 R4 res_count", res_count, ec);
      check("R5 R6 rd_ptr", rd_ptr, VEC[k][16:1]);
      check("R7 exhausted", exhausted, VEC[k][0]);
      check("R3 four reads", ack_cnt - a0, 4);
    end

    // R10: command and pointer write during a fetch are ignored
    do_reset();
    wide_mode = 1'b0; wait_cfg = 2'd2;
    write_ptr(2'd0, 16'h0000);
    write_ptr(2'd1, 16'h1000);
    write_ptr(2'd2, 16'h0040);
    write_ptr(2'd3, 16'h0800);
    begin
      int a0;
      a0 = ack_cnt;
      pulse_cmd();
      fetch_cmd = 1'b1; ptr_wr_en = 1'b1; ptr_wr_sel = 2'd2; ptr_wr_data = 16'h0300;
      @(negedge clk);
      fetch_cmd = 1'b0; ptr_wr_en = 1'b0;
      check("R10 busy during fetch", busy, 1);
      wait_idle();
      check("R10 one fetch only", ack_cnt - a0, 4);
      check("R10 rd write ignored", rd_ptr, 16'h0048);
      check("R8 idle after fetch", busy, 0);
    end
    wait_cfg = 2'd0;

    // R7 stickiness and R9 clear with refetch
    do_reset();
    wide_mode = 1'b0;
    write_ptr(2'd0, 16'h0100);
    write_ptr(2'd1, 16'h0110);
    write_ptr(2'd2, 16'h0108);
    write_ptr(2'd3, 16'h0100);
    pulse_cmd();
    wait_idle();
    check("R7 exhausted on hit", exhausted, 1);
    check("R6 wrapped rd", rd_ptr, 16'h0100);
    pulse_cmd();
    wait_idle();
    check("R7 sticky", exhausted, 1);
    check("R5 rd after second fetch", rd_ptr, 16'h0108);
    pulse_clr();
    check("R9 cleared", exhausted, 0);
    check("R9 refetch started", busy, 1);
    wait_idle();
    check("R9 refetch rd", rd_ptr, 16'h0100);
    check("R9 refetch exhausted again", exhausted, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule